// File: doc/BRIEF.md
# Two-Register Serial Control Slave

This block is a two-wire serial bus (I2C) target that holds two 8-bit control registers, selected by pointer values 0 and 1. A bus master reaches it with a 7-bit device address. The upper six address bits come from a parameter, and the lowest bit comes from a strap input. That input lets two instances share one bus. Bus lines arrive as oversampled levels from the pads. The block answers by pulling the data line low through an open-drain enable.

Several transfer types are supported. A master can write one register after a pointer byte. It can also write both registers in one burst that starts at pointer 0. To read, the master first sends a write that carries only the pointer and ends with STOP. It then starts a new read transfer, which returns the register the pointer selects. If the master acknowledges that byte, the block streams the other register next. The low six bits of register 0 appear on a separate output as a margin offset code, with a weight of 12.5 mV per step.

The registers clear when the power-good input drops, and also when the active-low clear input is asserted. Neither of these touches the bus state machine, the stored pointer or the data-line enable. Writing 0x00 over the bus has the same effect on a register.

Top module: `i2c_dual_reg_slave`

## Requirements
- R1: While and after `rst` is high, both registers read 0x00, `margin_code` is 0 and `sda_oe` is 0.
- R2: A write of START, device address with R/W=0, pointer byte 0x01, data byte, STOP acknowledges all three bytes and stores the data in register 1 only.
- R3: A write that starts with pointer 0x00 stores the first data byte in register 0 and the second in register 1. A third data byte wraps past register 1: it is acknowledged but not stored.
- R4: A pointer byte above 0x01 is not acknowledged, and no later byte of that transfer is acknowledged or stored.
- R5: The device address is `{DEV_ADDR[6:1], addr_sel}`. Any other address is not acknowledged, and the block then ignores the transfer.
- R6: After a write that sends only a pointer and then STOP, each later read transfer returns the selected register, MSB first. Reads do not change the stored pointer.
- R7: In a read, a master ACK (SDA low) makes the block send the other register next, so the order is 0, 1, 0 and so on. After a master NACK the block leaves SDA released until the next START or STOP.
- R8: When `clr_n` is low, both registers are 0x00 on the next cycle. A transfer in progress goes on and can still store data.
- R9: When `pwr_good` is low, both registers are 0x00 on the next cycle.
- R10: `margin_code` equals register 0 bits 5:0, and bits 7:6 have no effect on it. The offset is the code times 12.5 mV, so code 9 means 112.5 mV.
- R11: A START in the middle of a byte drops that byte without storing it and returns the block to address reception.
- R12: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pwr_good | input | 1 | Supply good; low clears both registers |
| clr_n | input | 1 | Active-low register clear |
| addr_sel | input | 1 | Device address bit 0 |
| scl_in | input | 1 | Bus clock level from the pad |
| sda_in | input | 1 | Bus data level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg0_q | output | 8 | Register 0 contents |
| reg1_q | output | 8 | Register 1 contents |
| margin_code | output | 6 | Offset code from register 0 |

## Verification
The hardest conditions to reach from the ports all happen in the middle of a transfer. These are a START that arrives partway through a byte, a clear pulse that falls between a pointer acknowledge and the next data byte, and the bit slots a master keeps clocking after it has NACKed a burst read. The bench reaches them with a bit-level master model. Its tasks can stop after any bit, issue a repeated START, pulse the clear between two bytes, and keep clocking with SDA released so it can watch for any pull-down from the block. A monitor runs for the whole run and catches any change on the data-line enable while SCL is high.

// File: rtl/i2c2r_pkg.sv
package i2c2r_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } i2c2r_state_e;
endpackage

// File: rtl/i2c2r_sync.sv
module i2c2r_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_in};
          sda_ff <= {sda_ff[STAGES-2:0], sda_in};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_in;
          sda_ff <= sda_in;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c2r_regs.sv
module i2c2r_regs #(
  parameter int W = 8,
  parameter int N = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           clr,
  input  logic           we,
  input  logic [IW-1:0]  widx,
  input  logic [W-1:0]   wdata,
  input  logic [IW-1:0]  ridx,
  output logic [W-1:0]   rdata,
  output logic [N*W-1:0] q_flat
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];

  generate
    for (genvar g = 0; g < N; g++) begin : g_out
      assign q_flat[g*W +: W] = mem[g];
    end
  endgenerate
endmodule

// File: rtl/i2c_dual_reg_slave.sv
module i2c_dual_reg_slave
  import i2c2r_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h4C,
  parameter int         SYNC_STAGES = 2,
  parameter int         MARGIN_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pwr_good,
  input  logic                clr_n,
  input  logic                addr_sel,
  input  logic                scl_in,
  input  logic                sda_in,
  output logic                sda_oe,
  output logic [BYTE_W-1:0]   reg0_q,
  output logic [BYTE_W-1:0]   reg1_q,
  output logic [MARGIN_W-1:0] margin_code
);
  localparam int REG_N = 2;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  i2c2r_state_e state;
  logic [2:0]        cnt;
  logic              got;
  logic              is_rd;
  logic [BYTE_W-1:0] sh;
  logic              ptr, wptr, wvalid, rptr;
  logic              reg_we, reg_widx;
  logic [BYTE_W-1:0] reg_wdata;
  logic              ridx;
  logic [BYTE_W-1:0] rdata;
  logic [REG_N*BYTE_W-1:0] q_flat;
  logic              reg_clr;
  logic [6:0]        my_addr;
  logic              in_idle;

  i2c2r_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign reg_clr = rst | ~pwr_good | ~clr_n;
  assign ridx    = (state == ST_ADDR_ACK) ? ptr : ~rptr;

  i2c2r_regs #(.W(BYTE_W), .N(REG_N)) u_regs (
    .clk(clk), .clr(reg_clr), .we(reg_we), .widx(reg_widx),
    .wdata(reg_wdata), .ridx(ridx), .rdata(rdata), .q_flat(q_flat)
  );

  assign my_addr     = {DEV_ADDR[6:1], addr_sel};
  assign reg0_q      = q_flat[BYTE_W-1:0];
  assign reg1_q      = q_flat[2*BYTE_W-1:BYTE_W];
  assign margin_code = reg0_q[MARGIN_W-1:0];
  assign in_idle     = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      got       <= 1'b0;
      is_rd     <= 1'b0;
      sh        <= '0;
      sda_oe    <= 1'b0;
      ptr       <= 1'b0;
      wptr      <= 1'b0;
      wvalid    <= 1'b0;
      rptr      <= 1'b0;
      reg_we    <= 1'b0;
      reg_widx  <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        got    <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        cnt    <= '0;
        got    <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) got <= 1'b1;
            end else if (scl_fall && got) begin
              got <= 1'b0;
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (sh[7:1] == my_addr) begin
                  sda_oe <= 1'b1;
                  is_rd  <= sh[0];
                  state  <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IGNORE;
                end
              end else if (state == ST_PTR) begin
                if (sh[7:1] == 7'd0) begin
                  sda_oe <= 1'b1;
                  ptr    <= sh[0];
                  wptr   <= sh[0];
                  wvalid <= 1'b1;
                  state  <= ST_PTR_ACK;
                end else begin
                  state <= ST_IGNORE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_WDATA_ACK;
                if (wvalid) begin
                  reg_we    <= 1'b1;
                  reg_widx  <= wptr;
                  reg_wdata <= sh;
                end
                if (wptr) wvalid <= 1'b0;
                wptr <= ~wptr;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (is_rd) begin
                sda_oe <= ~rdata[7];
                sh     <= {rdata[6:0], 1'b0};
                rptr   <= ptr;
                cnt    <= '0;
                state  <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                sda_oe <= 1'b0;
                got    <= 1'b0;
                state  <= ST_RACK;
              end else begin
                sda_oe <= ~sh[7];
                sh     <= {sh[6:0], 1'b0};
                cnt    <= cnt + 3'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              got <= ~sda_s;
            end else if (scl_fall) begin
              got <= 1'b0;
              if (got) begin
                sda_oe <= ~rdata[7];
                sh     <= {rdata[6:0], 1'b0};
                rptr   <= ~rptr;
                cnt    <= '0;
                state  <= ST_RDATA;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c2r_checker.sv
module i2c2r_checker (
  input logic       clk,
  input logic       rst,
  input logic       pwr_good,
  input logic       clr_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic [7:0] reg0_q,
  input logic [7:0] reg1_q,
  input logic       in_idle
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!sda_oe && reg0_q == 8'h00 && reg1_q == 8'h00));

  a_r8_clear_wipes: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (reg0_q == 8'h00 && reg1_q == 8'h00));

  a_r9_pgood_wipes: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> (reg0_q == 8'h00 && reg1_q == 8'h00));

  a_r12_sda_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_s));

  a_r3_one_reg_per_byte: assert property (@(posedge clk) disable iff (rst)
    (!$stable(reg0_q) && !$stable(reg1_q)) |-> ($past(!clr_n) || $past(!pwr_good)));

  a_r7_idle_released: assert property (@(posedge clk) disable iff (rst)
    in_idle |-> !sda_oe);
endmodule

bind i2c_dual_reg_slave i2c2r_checker u_chk (
  .clk(clk), .rst(rst), .pwr_good(pwr_good), .clr_n(clr_n), .scl_s(scl_s),
  .sda_oe(sda_oe), .reg0_q(reg0_q), .reg1_q(reg1_q), .in_idle(in_idle)
);

// File: tb/i2c_dual_reg_slave_test.sv
module i2c_dual_reg_slave_test;
  localparam int Q = 6;
  localparam logic [6:0] ADDR0 = 7'h4C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_good = 1'b1;
  logic clr_n = 1'b1;
  logic addr_sel = 1'b0;
  logic m_scl_low = 1'b0;
  logic m_sda_low = 1'b0;
  logic sda_oe;
  logic [7:0] reg0_q, reg1_q;
  logic [5:0] margin_code;
  logic scl_in, sda_line;
  int n_chk = 0, n_err = 0, hi_changes = 0;
  logic oe_prev = 1'b0;

  always #10 clk = ~clk;

  assign scl_in   = ~m_scl_low;
  assign sda_line = ~(m_sda_low | sda_oe);

  i2c_dual_reg_slave uut (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .clr_n(clr_n), .addr_sel(addr_sel),
    .scl_in(scl_in), .sda_in(sda_line), .sda_oe(sda_oe),
    .reg0_q(reg0_q), .reg1_q(reg1_q), .margin_code(margin_code)
  );

  always @(negedge clk) begin
    if (!rst && sda_oe !== oe_prev && scl_in) hi_changes++;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; tick();
    m_scl_low = 1'b0; tick();
    m_sda_low = 1'b1; tick();
    m_scl_low = 1'b1; tick();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; tick();
    m_scl_low = 1'b0; tick();
    m_sda_low = 1'b0; tick();
  endtask

  task automatic put_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      m_sda_low = ~b[i]; tick();
      m_scl_low = 1'b0; tick();
      m_scl_low = 1'b1; tick();
    end
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    put_bits(b, 8);
    m_sda_low = 1'b0; tick();
    m_scl_low = 1'b0; tick();
    ack = ~sda_line; tick();
    m_scl_low = 1'b1; tick();
  endtask

  task automatic get_byte(input bit mack, output logic [7:0] b);
    b = '0;
    m_sda_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick();
      m_scl_low = 1'b0; tick();
      b = {b[6:0], sda_line}; tick();
      m_scl_low = 1'b1;
    end
    tick();
    m_sda_low = mack; tick();
    m_scl_low = 1'b0; tick(); tick();
    m_scl_low = 1'b1; tick();
    m_sda_low = 1'b0;
  endtask

  task automatic set_ptr(input logic [6:0] a, input logic [7:0] p, output bit aa, output bit pa);
    bus_start();
    put_byte({a, 1'b0}, aa);
    put_byte(p, pa);
    bus_stop();
  endtask

  task automatic t_reset();
    chk(reg0_q == 8'h00 && reg1_q == 8'h00, "R1 regs after reset", {reg0_q, reg1_q}, 16'h0000);
    chk(sda_oe == 1'b0 && margin_code == 6'd0, "R1 sda/margin after reset", {sda_oe, margin_code}, 0);
  endtask

  task automatic t_single_write();
    bit a0, a1, a2;
    bus_start();
    put_byte({ADDR0, 1'b0}, a0);
    put_byte(8'h01, a1);
    put_byte(8'hA5, a2);
    bus_stop();
    chk(a0 && a1 && a2, "R2 single write acks", {a0, a1, a2}, 3'b111);
    chk(reg1_q == 8'hA5 && reg0_q == 8'h00, "R2 single write data", {reg0_q, reg1_q}, 16'h00A5);
  endtask

  task automatic t_burst_write();
    bit a0, a1, a2, a3, a4;
    bus_start();
    put_byte({ADDR0, 1'b0}, a0);
    put_byte(8'h00, a1);
    put_byte(8'h49, a2);
    put_byte(8'h3C, a3);
    put_byte(8'h77, a4);
    bus_stop();
    chk(a0 && a1 && a2 && a3 && a4, "R3 burst acks incl wrapped", {a0, a1, a2, a3, a4}, 5'h1F);
    chk(reg0_q == 8'h49 && reg1_q == 8'h3C, "R3 burst data, wrap not stored", {reg0_q, reg1_q}, 16'h493C);
    chk(margin_code == 6'd9, "R10 code 9 (112.5mV), bits 7:6 ignored", margin_code, 6'd9);
  endtask

  task automatic t_bad_ptr();
    bit a0, a1, a2;
    bus_start();
    put_byte({ADDR0, 1'b0}, a0);
    put_byte(8'h02, a1);
    put_byte(8'h55, a2);
    bus_stop();
    chk(a0 && !a1 && !a2, "R4 pointer 2 nacked", {a0, a1, a2}, 3'b100);
    chk(reg0_q == 8'h49 && reg1_q == 8'h3C, "R4 no store", {reg0_q, reg1_q}, 16'h493C);
  endtask

  task automatic t_address();
    bit a0, a1, a2;
    bus_start();
    put_byte({7'h2C, 1'b0}, a0);
    put_byte(8'h00, a1);
    put_byte(8'hEE, a2);
    bus_stop();
    chk(!a0 && !a1 && !a2, "R5 wrong address ignored", {a0, a1, a2}, 3'b000);
    chk(reg0_q == 8'h49, "R5 wrong address no store", reg0_q, 8'h49);
    addr_sel = 1'b1;
    bus_start();
    put_byte({ADDR0 | 7'h01, 1'b0}, a0);
    put_byte(8'h00, a1);
    put_byte(8'h05, a2);
    bus_stop();
    chk(a0 && a1 && a2 && reg0_q == 8'h05, "R5 addr_sel=1 selects 0x4D", {a0, a1, a2, reg0_q}, {3'b111, 8'h05});
    chk(margin_code == 6'd5, "R10 margin follows reg0", margin_code, 6'd5);
    bus_start();
    put_byte({ADDR0, 1'b0}, a0);
    bus_stop();
    chk(!a0, "R5 0x4C nacked when addr_sel=1", a0, 0);
    addr_sel = 1'b0;
  endtask

  task automatic t_pointer_read();
    bit aa, pa, ra;
    logic [7:0] d;
    set_ptr(ADDR0, 8'h01, aa, pa);
    chk(aa && pa, "R6 pointer-only write acked", {aa, pa}, 2'b11);
    for (int k = 0; k < 2; k++) begin
      bus_start();
      put_byte({ADDR0, 1'b1}, ra);
      get_byte(1'b0, d);
      bus_stop();
      chk(ra && d == 8'h3C, "R6 read returns reg1, pointer kept", {ra, d}, {1'b1, 8'h3C});
    end
  endtask

  task automatic t_burst_read();
    bit aa, pa, ra;
    logic [7:0] d0, d1, d2, d3;
    set_ptr(ADDR0, 8'h00, aa, pa);
    bus_start();
    put_byte({ADDR0, 1'b1}, ra);
    get_byte(1'b1, d0);
    get_byte(1'b1, d1);
    get_byte(1'b0, d2);
    get_byte(1'b0, d3);
    bus_stop();
    chk(ra && d0 == 8'h05 && d1 == 8'h3C, "R7 burst read order 0 then 1", {d0, d1}, 16'h053C);
    chk(d2 == 8'h05, "R7 burst read wraps to reg0", d2, 8'h05);
    chk(d3 == 8'hFF, "R7 released after NACK", d3, 8'hFF);
  endtask

  task automatic t_clear();
    bit a0, a1, a2;
    bus_start();
    put_byte({ADDR0, 1'b0}, a0);
    put_byte(8'h01, a1);
    clr_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(reg0_q == 8'h00 && reg1_q == 8'h00, "R8 clear wipes regs", {reg0_q, reg1_q}, 16'h0000);
    clr_n = 1'b1;
    put_byte(8'h66, a2);
    bus_stop();
    chk(a0 && a1 && a2 && reg1_q == 8'h66 && reg0_q == 8'h00, "R8 transfer survives clear",
        {a2, reg0_q, reg1_q}, {1'b1, 8'h00, 8'h66});
  endtask

  task automatic t_pgood();
    bit a0, a1, a2;
    bus_start();
    put_byte({ADDR0, 1'b0}, a0);
    put_byte(8'h00, a1);
    put_byte(8'h80, a2);
    bus_stop();
    chk(reg0_q == 8'h80 && margin_code == 6'd0, "R10 bits 7:6 do not reach margin", {reg0_q, margin_code}, {8'h80, 6'd0});
    pwr_good = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(reg0_q == 8'h00 && reg1_q == 8'h00, "R9 power-good drop clears", {reg0_q, reg1_q}, 16'h0000);
    pwr_good = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_abort();
    bit a0, a1, a2;
    bus_start();
    put_byte({ADDR0, 1'b0}, a0);
    put_byte(8'h01, a1);
    put_bits(8'hB0, 4);
    bus_start();
    put_byte({ADDR0, 1'b0}, a0);
    put_byte(8'h00, a1);
    put_byte(8'h12, a2);
    bus_stop();
    chk(a0 && a1 && a2 && reg0_q == 8'h12, "R11 restart after mid-byte START", {a2, reg0_q}, {1'b1, 8'h12});
    chk(reg1_q == 8'h00, "R11 aborted byte not stored", reg1_q, 8'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_single_write();
    t_burst_write();
    t_bad_ptr();
    t_address();
    t_pointer_read();
    t_burst_read();
    t_clear();
    t_pgood();
    t_abort();
    chk(hi_changes == 0, "R12 sda_oe changed while SCL high", hi_changes, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule